// File: doc/BRIEF.md
# RMII Receive Deframer

This block sits directly behind the receive side of a reduced media-independent Ethernet PHY running at 100 Mb/s. It samples a two-bit data bus and a data-valid line on every rising edge of the 50 MHz reference clock. While data-valid is high it first skips any idle `00` dibits and the `01` preamble pattern. It then waits for the `11` dibit that opens the frame.

From that point on, it collects groups of four dibits into bytes, taking the least significant pair first. Each byte is presented with a one-cycle strobe. Each byte is also folded into a running CRC-32, so no separate check pass is needed.

When data-valid drops, the block emits a one-cycle end-of-frame pulse with a good/bad verdict. The byte count of the frame stays visible until the next frame opens. A downstream consumer can write the byte stream into a buffer and commit or discard it on the end pulse.

Top module: `rmii_rx_deframer`

## Requirements
- R1: A synchronous active-high reset clears the byte strobe, the end pulse, the good flag and the byte count, and returns the block to hunting for a frame.
- R2: While data-valid is high before the delimiter, dibits `00` and `01` produce no bytes; any number of leading `00` dibits may come before the `01` preamble.
- R3: A `11` dibit opens the frame only when it directly follows at least one `01` dibit. A `11` seen before any preamble is ignored, and the dibit after the opening `11` is bit 1:0 of the first byte.
- R4: Four consecutive data dibits form one byte with the first dibit in bits 1:0, then 3:2, 5:4 and 7:6. The byte appears on the data output with a one-cycle strobe in the cycle after the edge that samples the fourth dibit.
- R5: The CRC register starts at all ones on each delimiter and advances per byte with the reflected polynomial 0xEDB88320. The frame is good when, after all bytes including the four check bytes, the register equals 0xDEBB20E3. A frame of 64 zero bytes followed by 36 63 8D 75 is good.
- R6: A frame whose check bytes do not match its contents is reported bad.
- R7: If data-valid falls while a byte is partly assembled (dibit count not a multiple of four), the frame is reported bad.
- R8: If data-valid falls before a delimiter has been seen, an end pulse is still issued, marked bad, and no bytes are produced.
- R9: A frame of fewer than 64 bytes (check bytes included) is reported bad even when its CRC is correct; exactly 64 bytes with a correct CRC is good.
- R10: The end pulse lasts exactly one cycle and appears in the cycle after the edge that first samples data-valid low. The good flag is high only together with the end pulse.
- R11: The 12-bit byte count is cleared at each delimiter and increments with every byte. It saturates at 4095 and holds its value after the frame ends until the next delimiter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz receive reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rxValid | input | 1 | Carrier / data-valid from the PHY |
| rxDibit | input | 2 | Receive data pair from the PHY |
| byteData | output | 8 | Last assembled byte |
| byteValid | output | 1 | One-cycle strobe for byteData |
| frameEnd | output | 1 | One-cycle end-of-frame pulse |
| frameGood | output | 1 | Verdict, valid with frameEnd |
| byteCount | output | 12 | Bytes received since the last delimiter |

## Verification
Each byte strobe is due one cycle after the edge that samples that byte's fourth dibit. The end pulse is due one cycle after the edge that samples data-valid low. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, before it drives again. So every observation lands exactly one register stage after the stimulus that caused it.

Bytes are compared in order against the frame the bench built. The end pulse must show up on the second falling edge of the idle tail and nowhere else. The verdict and the count are taken from that same cycle.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  localparam logic [1:0] DIBIT_IDLE  = 2'b00;
  localparam logic [1:0] DIBIT_PRE   = 2'b01;
  localparam logic [1:0] DIBIT_START = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_PRE,
    ST_DATA
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic takeDibit;
    logic endFrame;
    logic inData;
  } rxStrobes_t;

  function automatic logic [31:0] crcByte(input logic [31:0] crcIn,
                                          input logic [7:0]  dataIn);
    logic [31:0] c;
    c = crcIn ^ {24'd0, dataIn};
    for (int b = 0; b < 8; b++) begin
      if (c[0]) c = (c >> 1) ^ CRC_POLY;
      else      c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
  import rmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rxValid,
  input  logic [1:0] rxDibit,
  output rxStrobes_t strobes
);

  rxState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    if (!rxValid) begin
      stateNext = ST_IDLE;
      if (state != ST_IDLE) begin
        strobes.endFrame = 1'b1;
        strobes.inData   = (state == ST_DATA);
      end
    end else begin
      unique case (state)
        ST_IDLE, ST_HUNT: begin
          if (rxDibit == DIBIT_PRE) stateNext = ST_PRE;
          else                      stateNext = ST_HUNT;
        end
        ST_PRE: begin
          if (rxDibit == DIBIT_START) begin
            stateNext          = ST_DATA;
            strobes.startFrame = 1'b1;
          end else if (rxDibit != DIBIT_PRE) begin
            stateNext = ST_HUNT;
          end
        end
        ST_DATA: begin
          strobes.takeDibit = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  // R3: data state is only reached through a start dibit after preamble
  a_r3_sfd_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |->
      $past(state == ST_DATA || (state == ST_PRE && rxValid && rxDibit == DIBIT_START)));

  // R2: no strobe pair ever fires together
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.startFrame, strobes.takeDibit, strobes.endFrame}));

  // R10: a drop of carrier always lands the control in idle
  a_r10_drop_idle: assert property (@(posedge clk) disable iff (rst)
    !rxValid |=> state == ST_IDLE);

endmodule

// File: rtl/rmii_rx_dp.sv
module rmii_rx_dp
  import rmii_rx_pkg::*;
#(
  parameter int COUNT_W   = 12,
  parameter int MIN_FRAME = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         rxDibit,
  input  rxStrobes_t         strobes,
  output logic [7:0]         byteData,
  output logic               byteValid,
  output logic               frameEnd,
  output logic               frameGood,
  output logic [COUNT_W-1:0] byteCount
);

  localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] COUNT_MIN = COUNT_W'(MIN_FRAME);

  logic [1:0]  phase;
  logic [5:0]  partial;
  logic [7:0]  fullByte;
  logic [31:0] crcReg;

  assign fullByte = {rxDibit, partial};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      partial   <= '0;
      crcReg    <= CRC_INIT;
      byteCount <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
      frameEnd  <= 1'b0;
      frameGood <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      frameEnd  <= 1'b0;
      frameGood <= 1'b0;
      if (strobes.startFrame) begin
        phase     <= '0;
        crcReg    <= CRC_INIT;
        byteCount <= '0;
      end else if (strobes.takeDibit) begin
        partial <= fullByte[7:2];
        phase   <= phase + 2'd1;
        if (phase == 2'd3) begin
          byteData  <= fullByte;
          byteValid <= 1'b1;
          crcReg    <= crcByte(crcReg, fullByte);
          if (byteCount != COUNT_MAX) byteCount <= byteCount + 1'b1;
        end
      end
      if (strobes.endFrame) begin
        frameEnd  <= 1'b1;
        frameGood <= strobes.inData && (phase == 2'd0) &&
                     (byteCount >= COUNT_MIN) && (crcReg == CRC_RESIDUE);
      end
    end
  end

  // R4: a byte strobe follows a consumed dibit
  a_r4_strobe_source: assert property (@(posedge clk) disable iff (rst)
    byteValid |-> $past(strobes.takeDibit));

  // R10: end pulse is a single cycle
  a_r10_single_end: assert property (@(posedge clk) disable iff (rst)
    frameEnd |=> !frameEnd);

  // R10: verdict only alongside the end pulse
  a_r10_good_at_end: assert property (@(posedge clk) disable iff (rst)
    frameGood |-> frameEnd);

  // R9: a good verdict implies the minimum length
  a_r9_min_length: assert property (@(posedge clk) disable iff (rst)
    frameGood |-> byteCount >= COUNT_MIN);

  // R11: the count never wraps downward except at a delimiter
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !strobes.startFrame |=> byteCount >= $past(byteCount));

endmodule

// File: rtl/rmii_rx_deframer.sv
module rmii_rx_deframer
  import rmii_rx_pkg::*;
#(
  parameter int COUNT_W   = 12,
  parameter int MIN_FRAME = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rxValid,
  input  logic [1:0]         rxDibit,
  output logic [7:0]         byteData,
  output logic               byteValid,
  output logic               frameEnd,
  output logic               frameGood,
  output logic [COUNT_W-1:0] byteCount
);

  rxStrobes_t strobes;

  rmii_rx_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rxValid (rxValid),
    .rxDibit (rxDibit),
    .strobes (strobes)
  );

  rmii_rx_dp #(
    .COUNT_W   (COUNT_W),
    .MIN_FRAME (MIN_FRAME)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .rxDibit   (rxDibit),
    .strobes   (strobes),
    .byteData  (byteData),
    .byteValid (byteValid),
    .frameEnd  (frameEnd),
    .frameGood (frameGood),
    .byteCount (byteCount)
  );

endmodule

// File: tb/sim_rmii_rx_deframer.sv
module sim_rmii_rx_deframer;

  localparam int CLK_PERIOD = 20;
  localparam int MAX_LEN    = 4110;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxValid = 1'b0;
  logic [1:0]  rxDibit = 2'b00;
  logic [7:0]  byteData;
  logic        byteValid;
  logic        frameEnd;
  logic        frameGood;
  logic [11:0] byteCount;

  rmii_rx_deframer u0 (
    .clk       (clk),
    .rst       (rst),
    .rxValid   (rxValid),
    .rxDibit   (rxDibit),
    .byteData  (byteData),
    .byteValid (byteValid),
    .frameEnd  (frameEnd),
    .frameGood (frameGood),
    .byteCount (byteCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic [7:0] frameBuf [MAX_LEN];
  int rxIdx, byteErr, endSeen, endAt, tailPos;
  bit endGoodSeen;
  int endCount;

  function automatic logic [31:0] benchCrc(input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {24'd0, frameBuf[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    if (byteValid) begin
      if (rxIdx < MAX_LEN && byteData !== frameBuf[rxIdx]) byteErr++;
      rxIdx++;
    end
    if (frameEnd) begin
      endSeen++;
      endAt       = tailPos;
      endGoodSeen = frameGood;
      endCount    = int'(byteCount);
    end
  endtask

  task automatic tick(input logic v, input logic [1:0] d);
    @(negedge clk);
    observe();
    rxValid = v;
    rxDibit = d;
  endtask

  // build payload plus appended check bytes; returns total length
  function automatic int buildFrame(input int payload, input bit corrupt);
    logic [31:0] fcs;
    for (int i = 0; i < payload; i++) frameBuf[i] = 8'($urandom);
    fcs = ~benchCrc(payload);
    for (int k = 0; k < 4; k++) frameBuf[payload+k] = fcs[8*k +: 8];
    if (corrupt) begin
      int pos = int'($urandom % 32'(payload + 4));
      frameBuf[pos] = frameBuf[pos] ^ (8'd1 << ($urandom % 8));
    end
    return payload + 4;
  endfunction

  task automatic runFrame(input int len, input int lead, input int pre, input int extra,
                          input bit sfd, input bit stray, input bit expGood, input string req);
    rxIdx = 0; byteErr = 0; endSeen = 0; endAt = -1; tailPos = 0;
    if (stray) tick(1'b1, 2'b11);
    for (int i = 0; i < lead; i++) tick(1'b1, 2'b00);
    for (int i = 0; i < pre; i++) tick(1'b1, 2'b01);
    if (sfd) begin
      tick(1'b1, 2'b11);
      for (int i = 0; i < len; i++)
        for (int k = 0; k < 4; k++) tick(1'b1, frameBuf[i][2*k +: 2]);
      for (int i = 0; i < extra; i++) tick(1'b1, 2'($urandom));
    end
    for (int t = 1; t <= 5; t++) begin
      tailPos = t;
      tick(1'b0, 2'b00);
    end
    check(rxIdx == (sfd ? len : 0), "R4", {req, " byte count seen"}, rxIdx, sfd ? len : 0);
    check(byteErr == 0, "R4", {req, " byte values"}, byteErr, 0);
    check(endSeen == 1, "R10", {req, " end pulses"}, endSeen, 1);
    check(endAt == 2, "R10", {req, " end pulse timing"}, endAt, 2);
    check(endGoodSeen == expGood, req, "verdict", int'(endGoodSeen), int'(expGood));
    if (sfd) begin
      int expCount = (len > 4095) ? 4095 : len;
      check(endCount == expCount, "R11", {req, " count at end"}, endCount, expCount);
      check(int'(byteCount) == expCount, "R11", {req, " count held"}, int'(byteCount), expCount);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(byteValid == 1'b0, "R1", "byteValid after reset", int'(byteValid), 0);
    check(frameEnd == 1'b0, "R1", "frameEnd after reset", int'(frameEnd), 0);
    check(byteCount == 12'd0, "R1", "byteCount after reset", int'(byteCount), 0);

    // R5 directed zero frame with known check bytes
    for (int i = 0; i < 64; i++) frameBuf[i] = 8'h00;
    frameBuf[64] = 8'h36; frameBuf[65] = 8'h63; frameBuf[66] = 8'h8D; frameBuf[67] = 8'h75;
    runFrame(68, 3, 31, 0, 1'b1, 1'b0, 1'b1, "R5");

    // R2 R3 random good frames with idle lead-in, varying preamble, stray start dibit
    for (int f = 0; f < 8; f++) begin
      len = buildFrame(60 + int'($urandom % 140), 1'b0);
      runFrame(len, int'($urandom % 6), 1 + int'($urandom % 31), 0, 1'b1,
               1'(f % 2), 1'b1, (f % 2) ? "R3" : "R2");
    end

    // R6 corrupted frames
    for (int f = 0; f < 3; f++) begin
      len = buildFrame(64 + int'($urandom % 80), 1'b1);
      runFrame(len, 2, 20, 0, 1'b1, 1'b0, 1'b0, "R6");
    end

    // R7 partial trailing byte
    for (int f = 0; f < 3; f++) begin
      len = buildFrame(70, 1'b0);
      runFrame(len, 1, 15, 1 + f, 1'b1, 1'b0, 1'b0, "R7");
    end

    // R8 carrier drops before delimiter
    runFrame(0, 4, 10, 0, 1'b0, 1'b0, 1'b0, "R8");
    runFrame(0, 6, 0, 0, 1'b0, 1'b1, 1'b0, "R8");

    // R9 short frames and the 64-byte boundary
    len = buildFrame(20, 1'b0);
    runFrame(len, 0, 8, 0, 1'b1, 1'b0, 1'b0, "R9");
    len = buildFrame(59, 1'b0);
    runFrame(len, 0, 8, 0, 1'b1, 1'b0, 1'b0, "R9");
    len = buildFrame(60, 1'b0);
    runFrame(len, 0, 8, 0, 1'b1, 1'b0, 1'b1, "R9");

    // R11 count saturation on a long frame
    len = buildFrame(4100, 1'b0);
    runFrame(len, 0, 4, 0, 1'b1, 1'b0, 1'b1, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule